// File: doc/BRIEF.md
# Commutative-Update Coherent Word Directory

This block keeps one shared data word coherent across a set of private cache slices and a central directory. Each client port talks to its own slice. A slice holds the word in one of four stable states: invalid, shared read-only, update-only, or modified. Reads, writes and commutative updates that the slice can satisfy with its current permission complete inside the slice. Any request the slice cannot satisfy is passed to the directory, which serves one such miss at a time.

The update-only state lets many slices take commutative updates on the word at the same time. A slice that enters this state starts its copy at the identity of the operation, which is zero for both integer add and bitwise or. From then on it folds later updates of the same operation into its private partial value, and the directory is not involved. The directory keeps the home value. When the full value is needed, because of a read, a write or an update of the other operation, a reduction unit combines the home value with every partial value under the line's operation and then invalidates the update-only copies.

Top module: `cupd_word_dir`

## Requirements
- R1: After the synchronous active-high reset, every port shows ready and no response is pending, and the first read returns the INIT parameter (default 0).
- R2: The request kind is encoded as 0 = read, 1 = write, 2 = commutative update and 3 = read. The operation bit is 0 = add and 1 = or. Each accepted request produces exactly one response pulse. The response data carries the word for reads and is zero for writes and updates.
- R3: A request is a local hit in these cases: a read in shared or modified state, a write in modified state, an update of either operation in modified state, and an update in update-only state with the same operation. A hit raises the response in the cycle right after the accepting edge.
- R4: Any other request is a miss. When the directory is idle and no other miss is waiting, the response of a miss is raised by the second clock edge after the accepting edge.
- R5: A slice granted update-only holds just the delta it was granted with. Granting update-only with the same operation to another slice leaves existing holders in place, and their next same-operation update is still a local hit.
- R6: A read while the word is update-only returns the home value combined with all partial values under the line's operation. It also invalidates every update-only copy.
- R7: A read while another slice holds modified returns that slice's value and downgrades the owner to shared, so that the owner's next read is a local hit.
- R8: A write invalidates all other copies, folds any partial values into the home value, and leaves the writer in modified state holding the written data.
- R9: An update whose operation differs from that of the update-only line first reduces the line under the old operation and then grants update-only under the new operation. The logical value becomes the reduced value combined with the new delta.
- R10: An update from a slice while the line is shared invalidates all shared copies before update-only is granted.
- R11: Add updates and add reductions wrap modulo 2^W.
- R12: Under any interleaving of add updates from all ports, a later read returns the starting value plus the sum of all deltas, modulo 2^W.
- R13: At most one slice holds modified state. A modified owner never coexists with shared or update-only copies, and all update-only holders share one operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NP | Per-port request valid |
| req_ready | output | NP | Per-port request ready |
| req_kind | input | 2*NP | Per-port request kind, 2 bits each |
| req_op | input | NP | Per-port operation, 0 add, 1 or |
| req_data | input | W*NP | Per-port write data or update delta |
| resp_valid | output | NP | Per-port one-cycle response pulse |
| resp_data | output | W*NP | Per-port response word |

## Verification
Two things can land on the same clock edge: a local update-only hit at one port, and the directory picking or reducing a miss from another port. The bench provokes this by running every port at once with random add deltas and random gaps. While that runs, port 0 also issues occasional reads, whose values are left unchecked but which force reductions in the middle of the traffic. A final read must equal the starting value plus every delta issued. A partial value that a reduction lost or counted twice would show up as a wrong final word.

// File: rtl/cupd_pkg.sv
package cupd_pkg;

  typedef enum logic [1:0] {
    CS_INV = 2'd0,
    CS_SHR = 2'd1,
    CS_UPD = 2'd2,
    CS_MOD = 2'd3
  } cstate_e;

  typedef enum logic {
    DS_IDLE  = 1'b0,
    DS_SERVE = 1'b1
  } dstate_e;

  localparam logic [1:0] RK_READ  = 2'd0;
  localparam logic [1:0] RK_WRITE = 2'd1;
  localparam logic [1:0] RK_UPD   = 2'd2;

  localparam logic OP_ADD = 1'b0;
  localparam logic OP_OR  = 1'b1;

endpackage

// File: rtl/cupd_reduce.sv
module cupd_reduce #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic [W-1:0] home_i,
  input  logic [N-1:0] mask_i,
  input  logic [W-1:0] part_i [N],
  output logic [W-1:0] sum_o,
  output logic [W-1:0] or_o
);

  // Fold every selected partial value into the home value under both operations.
  always_comb begin
    sum_o = home_i;
    or_o  = home_i;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i]) begin
        sum_o = sum_o + part_i[i];
        or_o  = or_o | part_i[i];
      end
    end
  end

endmodule

// File: rtl/cupd_slice.sv
module cupd_slice
  import cupd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [1:0]   req_kind,
  input  logic         req_op,
  input  logic [W-1:0] req_data,
  output logic         resp_valid,
  output logic [W-1:0] resp_data,
  input  logic         dir_busy,
  output logic         miss_o,
  output logic [1:0]   miss_kind_o,
  output logic         miss_op_o,
  output logic [W-1:0] miss_data_o,
  output cstate_e      st_o,
  output logic [W-1:0] val_o,
  output logic         op_o,
  input  logic         cmd_inv,
  input  logic         cmd_down,
  input  logic         cmd_grant,
  input  cstate_e      grant_st,
  input  logic [W-1:0] grant_val,
  input  logic         grant_op,
  input  logic [W-1:0] grant_rdata
);

  cstate_e      st_q;
  logic [W-1:0] val_q;
  logic         op_q;
  logic         pend_q;
  logic [1:0]   mk_q;
  logic         mo_q;
  logic [W-1:0] md_q;

  logic is_wr, is_upd, is_rd, hit, accept;
  logic [W-1:0] upd_val;

  assign is_wr  = (req_kind == RK_WRITE);
  assign is_upd = (req_kind == RK_UPD);
  assign is_rd  = !is_wr && !is_upd;

  always_comb begin
    hit = 1'b0;
    if (is_rd)  hit = (st_q == CS_SHR) || (st_q == CS_MOD);
    if (is_wr)  hit = (st_q == CS_MOD);
    if (is_upd) hit = (st_q == CS_MOD) || ((st_q == CS_UPD) && (op_q == req_op));
  end

  assign upd_val   = (req_op == OP_OR) ? (val_q | req_data) : (val_q + req_data);
  assign req_ready = !pend_q && !dir_busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= CS_INV;
      val_q      <= '0;
      op_q       <= OP_ADD;
      pend_q     <= 1'b0;
      mk_q       <= RK_READ;
      mo_q       <= OP_ADD;
      md_q       <= '0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (cmd_grant) begin
        st_q       <= grant_st;
        val_q      <= grant_val;
        op_q       <= grant_op;
        pend_q     <= 1'b0;
        resp_valid <= 1'b1;
        resp_data  <= grant_rdata;
      end else if (cmd_inv) begin
        st_q <= CS_INV;
      end else if (cmd_down) begin
        st_q <= CS_SHR;
      end else if (accept) begin
        if (hit) begin
          resp_valid <= 1'b1;
          resp_data  <= is_rd ? val_q : '0;
          if (is_wr)  val_q <= req_data;
          if (is_upd) val_q <= upd_val;
        end else begin
          pend_q <= 1'b1;
          mk_q   <= req_kind;
          mo_q   <= req_op;
          md_q   <= req_data;
        end
      end
    end
  end

  assign miss_o      = pend_q;
  assign miss_kind_o = mk_q;
  assign miss_op_o   = mo_q;
  assign miss_data_o = md_q;
  assign st_o        = st_q;
  assign val_o       = val_q;
  assign op_o        = op_q;

  // R3: a local hit answers on the very next cycle
  p_hit_resp_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && hit) |=> resp_valid);

  // R4: a miss cannot be answered in the cycle after acceptance
  p_miss_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit) |=> !resp_valid);

  // R5: a same-operation update hit keeps the slice in update-only state
  p_upd_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && hit && is_upd && st_q == CS_UPD) |=> (st_q == CS_UPD));

endmodule

// File: rtl/cupd_dir.sv
module cupd_dir
  import cupd_pkg::*;
#(
  parameter int             N    = 4,
  parameter int             W    = 16,
  parameter logic [W-1:0]   INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] miss_i,
  input  logic [1:0]   kind_i [N],
  input  logic         mop_i  [N],
  input  logic [W-1:0] data_i [N],
  input  cstate_e      st_i   [N],
  input  logic [W-1:0] val_i  [N],
  input  logic         op_i   [N],
  output logic         busy_o,
  output logic [N-1:0] inv_o,
  output logic [N-1:0] down_o,
  output logic [N-1:0] grant_o,
  output cstate_e      gst_o,
  output logic [W-1:0] gval_o,
  output logic         gop_o,
  output logic [W-1:0] grdata_o
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  dstate_e      ds_q;
  logic [IW-1:0] sel_q, pick;
  logic [W-1:0] home_q, home_n;

  logic [N-1:0] mvec, svec, uvec, opvec;
  logic [W-1:0] mval, red_sum, red_or, full;
  logic         line_op, serving, keep_u;
  logic [1:0]   rk;
  logic         ro;
  logic [W-1:0] rd;

  always_comb begin
    mval = '0;
    for (int i = 0; i < N; i++) begin
      mvec[i]  = (st_i[i] == CS_MOD);
      svec[i]  = (st_i[i] == CS_SHR);
      uvec[i]  = (st_i[i] == CS_UPD);
      opvec[i] = op_i[i];
      if (st_i[i] == CS_MOD) mval = mval | val_i[i];
    end
  end

  cupd_reduce #(.N(N), .W(W)) u_reduce (
    .home_i (home_q),
    .mask_i (uvec),
    .part_i (val_i),
    .sum_o  (red_sum),
    .or_o   (red_or)
  );

  assign line_op = |(uvec & opvec);
  assign full    = (|mvec) ? mval
                 : (|uvec) ? ((line_op == OP_OR) ? red_or : red_sum)
                 : home_q;

  assign rk      = kind_i[sel_q];
  assign ro      = mop_i[sel_q];
  assign rd      = data_i[sel_q];
  assign serving = (ds_q == DS_SERVE);
  assign busy_o  = serving;
  assign keep_u  = (rk == RK_UPD) && (|uvec) && (line_op == ro);

  // Lowest-numbered waiting slice wins.
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (miss_i[i]) pick = IW'(i);
    end
  end

  always_comb begin
    inv_o    = '0;
    down_o   = '0;
    grant_o  = '0;
    gst_o    = CS_INV;
    gval_o   = '0;
    gop_o    = OP_ADD;
    grdata_o = '0;
    home_n   = home_q;
    if (serving) begin
      grant_o[sel_q] = 1'b1;
      if (rk == RK_WRITE) begin
        inv_o  = mvec | svec | uvec;
        gst_o  = CS_MOD;
        gval_o = rd;
        home_n = full;
      end else if (rk == RK_UPD) begin
        // The copy starts at the identity (zero), so after its first delta it holds rd.
        gst_o  = CS_UPD;
        gval_o = rd;
        gop_o  = ro;
        if (!keep_u) begin
          inv_o  = mvec | svec | uvec;
          home_n = full;
        end
      end else begin
        down_o   = mvec;
        inv_o    = uvec;
        gst_o    = CS_SHR;
        gval_o   = full;
        grdata_o = full;
        home_n   = full;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ds_q   <= DS_IDLE;
      sel_q  <= '0;
      home_q <= INIT;
    end else if (serving) begin
      ds_q   <= DS_IDLE;
      home_q <= home_n;
    end else if (|miss_i) begin
      ds_q  <= DS_SERVE;
      sel_q <= pick;
    end
  end

  // R13: never two owners
  p_one_owner_r13: assert property (@(posedge clk) disable iff (rst)
    $countones(mvec) <= 1);

  // R13: an owner excludes readers and updaters
  p_owner_alone_r13: assert property (@(posedge clk) disable iff (rst)
    (|mvec) |-> ((svec | uvec) == '0));

  // R13: update-only holders agree on the operation
  p_one_op_r13: assert property (@(posedge clk) disable iff (rst)
    ((uvec & opvec) == '0) || ((uvec & opvec) == uvec));

  // R4: grants only go to slices with a waiting miss
  p_grant_to_miss_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_o != '0) |-> ((grant_o & miss_i) == grant_o));

endmodule

// File: rtl/cupd_word_dir.sv
module cupd_word_dir
  import cupd_pkg::*;
#(
  parameter int           NP   = 4,
  parameter int           W    = 16,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NP-1:0]   req_valid,
  output logic [NP-1:0]   req_ready,
  input  logic [2*NP-1:0] req_kind,
  input  logic [NP-1:0]   req_op,
  input  logic [W*NP-1:0] req_data,
  output logic [NP-1:0]   resp_valid,
  output logic [W*NP-1:0] resp_data
);

  logic          busy;
  logic [NP-1:0] miss, inv, down, grant;
  logic [1:0]    mkind [NP];
  logic          mop   [NP];
  logic [W-1:0]  mdata [NP];
  cstate_e       st    [NP];
  logic [W-1:0]  val   [NP];
  logic          op    [NP];
  cstate_e       gst;
  logic [W-1:0]  gval, grdata;
  logic          gop;

  for (genvar g = 0; g < NP; g++) begin : g_slice
    cupd_slice #(.W(W)) u_slice (
      .clk         (clk),
      .rst         (rst),
      .req_valid   (req_valid[g]),
      .req_ready   (req_ready[g]),
      .req_kind    (req_kind[2*g +: 2]),
      .req_op      (req_op[g]),
      .req_data    (req_data[W*g +: W]),
      .resp_valid  (resp_valid[g]),
      .resp_data   (resp_data[W*g +: W]),
      .dir_busy    (busy),
      .miss_o      (miss[g]),
      .miss_kind_o (mkind[g]),
      .miss_op_o   (mop[g]),
      .miss_data_o (mdata[g]),
      .st_o        (st[g]),
      .val_o       (val[g]),
      .op_o        (op[g]),
      .cmd_inv     (inv[g]),
      .cmd_down    (down[g]),
      .cmd_grant   (grant[g]),
      .grant_st    (gst),
      .grant_val   (gval),
      .grant_op    (gop),
      .grant_rdata (grdata)
    );
  end

  cupd_dir #(.N(NP), .W(W), .INIT(INIT)) u_dir (
    .clk      (clk),
    .rst      (rst),
    .miss_i   (miss),
    .kind_i   (mkind),
    .mop_i    (mop),
    .data_i   (mdata),
    .st_i     (st),
    .val_i    (val),
    .op_i     (op),
    .busy_o   (busy),
    .inv_o    (inv),
    .down_o   (down),
    .grant_o  (grant),
    .gst_o    (gst),
    .gval_o   (gval),
    .gop_o    (gop),
    .grdata_o (grdata)
  );

endmodule

// File: tb/cupd_word_dir_tb_top.sv
`timescale 1ns/1ps
module cupd_word_dir_tb_top;

  localparam int NP = 4;
  localparam int W  = 16;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_UP = 2'd2, K_RD3 = 2'd3;
  localparam logic ADD = 1'b0, BOR = 1'b1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NP-1:0]   req_valid = '0;
  logic [NP-1:0]   req_ready;
  logic [2*NP-1:0] req_kind = '0;
  logic [NP-1:0]   req_op = '0;
  logic [W*NP-1:0] req_data = '0;
  logic [NP-1:0]   resp_valid;
  logic [W*NP-1:0] resp_data;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  logic [W-1:0] total;

  logic [W:0] exp_q [NP][$];
  string      tag_q [NP][$];

  always #4 clk = ~clk;

  cupd_word_dir #(.NP(NP), .W(W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_op(req_op), .req_data(req_data),
    .resp_valid(resp_valid), .resp_data(resp_data)
  );

  // Scoreboard monitor: compare each response with the queued expectation.
  always @(negedge clk) begin
    if (!rst) begin
      for (int p = 0; p < NP; p++) begin
        if (resp_valid[p]) begin
          if (exp_q[p].size() == 0) begin
            nchk++; nfail++;
            $display("FAIL R2 port %0d: response %h with nothing expected", p, resp_data[W*p +: W]);
          end else begin
            logic [W:0] e;
            string t;
            e = exp_q[p].pop_front();
            t = tag_q[p].pop_front();
            if (e[W]) begin
              nchk++;
              if (resp_data[W*p +: W] !== e[W-1:0]) begin
                nfail++;
                $display("FAIL %s port %0d: data %h expected %h", t, p, resp_data[W*p +: W], e[W-1:0]);
              end
            end
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  // Driver: starts and ends at a falling edge; pushes the expected item first.
  task automatic do_req(input int p, input logic [1:0] k, input logic o, input logic [W-1:0] d,
                        input logic [W-1:0] ed, input bit chk, input int elat, input string tag);
    int lat;
    exp_q[p].push_back({chk, ed});
    tag_q[p].push_back(tag);
    req_valid[p] = 1'b1;
    req_kind[2*p +: 2] = k;
    req_op[p] = o;
    req_data[W*p +: W] = d;
    while (!req_ready[p]) @(negedge clk);
    @(negedge clk);
    req_valid[p] = 1'b0;
    lat = 1;
    while (!resp_valid[p] && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    if (elat > 0) check(lat == elat, {tag, " latency"}, lat, elat);
  endtask

  task automatic run_port(input int p, input int nops, input bit rd_mix);
    for (int n = 0; n < nops; n++) begin
      logic [W-1:0] dl;
      repeat ($urandom_range(0, 3)) @(negedge clk);
      dl = W'($urandom_range(0, 65535));
      total = total + dl;
      do_req(p, K_UP, ADD, dl, '0, 1'b1, 0, "R12");
      if (rd_mix && p == 0 && $urandom_range(0, 4) == 0)
        do_req(p, K_RD, ADD, '0, '0, 1'b0, 0, "R12");
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check(req_ready == '1, "R1 ready after reset", int'(req_ready), 15);
    check(resp_valid == '0, "R1 no response after reset", int'(resp_valid), 0);
    do_req(0, K_RD, ADD, '0, 16'd0, 1, 3, "R1");
    // R8 write miss, R3 hits in modified state (R2: write response is zero)
    do_req(1, K_WR, ADD, 16'd100, 16'd0, 1, 3, "R8");
    do_req(1, K_WR, ADD, 16'd150, 16'd0, 1, 1, "R3");
    do_req(1, K_UP, ADD, 16'd5, 16'd0, 1, 1, "R3");
    // R7 downgrade of the owner
    do_req(2, K_RD, ADD, '0, 16'd155, 1, 3, "R7");
    do_req(1, K_RD, ADD, '0, 16'd155, 1, 1, "R7");
    // R10 update from shared line, R5 concurrent update-only holders
    do_req(0, K_UP, ADD, 16'd7, 16'd0, 1, 3, "R10");
    do_req(0, K_UP, ADD, 16'd3, 16'd0, 1, 1, "R5");
    do_req(3, K_UP, ADD, 16'd10, 16'd0, 1, 3, "R5");
    do_req(0, K_UP, ADD, 16'd1, 16'd0, 1, 1, "R5");
    do_req(3, K_UP, ADD, 16'd2, 16'd0, 1, 1, "R5");
    // R6 reduction on read; former shared reader misses (R10)
    do_req(1, K_RD, ADD, '0, 16'd178, 1, 3, "R6");
    do_req(0, K_UP, ADD, 16'd4, 16'd0, 1, 3, "R6");
    // R8 write folds and invalidates partials
    do_req(2, K_WR, ADD, 16'h00F0, 16'd0, 1, 3, "R8");
    do_req(0, K_RD, ADD, '0, 16'h00F0, 1, 3, "R8");
    // or-reduction
    do_req(1, K_UP, BOR, 16'h0100, 16'd0, 1, 3, "R10");
    do_req(3, K_UP, BOR, 16'h0001, 16'd0, 1, 3, "R5");
    do_req(1, K_UP, BOR, 16'h0200, 16'd0, 1, 1, "R3");
    do_req(2, K_RD, ADD, '0, 16'h03F1, 1, 3, "R6");
    // R9 operation switches
    do_req(1, K_UP, BOR, 16'h0008, 16'd0, 1, 3, "R9");
    do_req(3, K_UP, ADD, 16'h0007, 16'd0, 1, 3, "R9");
    do_req(1, K_UP, BOR, 16'h0001, 16'd0, 1, 3, "R9");
    do_req(0, K_RD, ADD, '0, 16'h0401, 1, 3, "R9");
    // R11 wrap-around through owner recall and reduction
    do_req(0, K_WR, ADD, 16'hFFF0, 16'd0, 1, 3, "R11");
    do_req(1, K_UP, ADD, 16'h0020, 16'd0, 1, 3, "R11");
    do_req(2, K_UP, ADD, 16'h0005, 16'd0, 1, 3, "R11");
    do_req(3, K_RD, ADD, '0, 16'h0015, 1, 3, "R11");
    // R3 owner applies both operations locally
    do_req(0, K_WR, ADD, 16'h0A00, 16'd0, 1, 3, "R8");
    do_req(0, K_UP, BOR, 16'h0050, 16'd0, 1, 1, "R3");
    do_req(0, K_UP, ADD, 16'h0001, 16'd0, 1, 1, "R3");
    do_req(0, K_RD, ADD, '0, 16'h0A51, 1, 1, "R3");
    // R2 kind 3 acts as read
    do_req(1, K_RD3, ADD, '0, 16'h0A51, 1, 3, "R2");
    // R12 concurrent add traffic, first plain then with reads mixed in
    v = 16'h0A51;
    for (int ph = 0; ph < 2; ph++) begin
      total = '0;
      for (int p = 0; p < NP; p++) begin
        automatic int pp = p;
        automatic bit mix = (ph == 1);
        fork
          run_port(pp, 40, mix);
        join_none
      end
      wait fork;
      @(negedge clk);
      v = v + total;
      do_req(1, K_RD, ADD, '0, v, 1, 3, "R12");
    end
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++)
      check(exp_q[p].size() == 0, "R2 all responses seen", exp_q[p].size(), 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule